// File: doc/BRIEF.md
# Daisy-Chain Interrupt Unit with Return Snooping

This block holds the interrupt side of a peripheral that can also become bus master on an 8-bit processor bus. When an internal event makes an interrupt pending, the unit pulls an open-drain, active-low request line. It recognises the processor's acknowledge cycle and, if it is granted by the priority chain, places its 8-bit vector on a data-out bus. It then stays "under service" until it sees the two-byte return-from-interrupt opcode go past on opcode fetches.

The unit sits in a priority daisy chain. A low level on the chain enable input means a device further up the chain is active. The unit passes that block on through its own chain enable output, and adds its own block while it has a request pending or is under service. While the unit owns the bus, the processor cannot take interrupts. During that time the request line carries single-clock pulses for an external device, and any pending interrupt is held back until the bus is released. All inputs are sampled on the rising clock edge. The strobe inputs are edge-detected, so that a strobe held low counts as one event.

Top module: `irq_chain_unit`

## Requirements
- R1: After a cycle with `irq_event` high, `irq_pull` is 1 (request line driven low) from the next cycle on, while `bus_master` is 0, until a granted acknowledge.
- R2: An acknowledge starts only in a cycle where `fetch_n` and `ioreq_n` are both 0 and were not both 0 in the previous cycle. Either strobe low on its own is not an acknowledge.
- R3: A granted acknowledge requires `chain_en_in` = 1 and a pending request. In the next cycle it gives `vec_oe` = 1 with `vec_out` equal to the parameter `VEC_ID` (default 0xA4), clears the pending request and sets under-service. `vec_oe` stays 1 while both strobes stay low and drops in the cycle after either strobe rises. `vec_out` is 0 whenever `vec_oe` is 0.
- R4: An acknowledge that starts with `chain_en_in` = 0, or with no request pending, has no effect: `vec_oe` stays 0 and `irq_pull` keeps its value.
- R5: `chain_en_out` is 1 only when `chain_en_in` is 1 and the unit has no pending request and is not under service.
- R6: An opcode fetch is a cycle where `fetch_n` falls to 0 while `ioreq_n` is 1, with the byte on `data_in`. A fetch of 0xED followed by a fetch of 0x4D as the very next fetch, with `chain_en_in` = 1 on the 0x4D fetch, clears under-service from the next cycle on.
- R7: A return sequence whose 0x4D fetch sees `chain_en_in` = 0 leaves under-service set. This keeps the state through a preempting higher-priority service.
- R8: A 0xED fetch followed by a fetch of any byte other than 0x4D or 0xED cancels the sequence, so a later lone 0x4D does nothing. A second 0xED keeps the sequence armed.
- R9: While `bus_master` is 1, a `pulse_event` cycle gives `irq_pull` = 1 for exactly the next cycle. `pulse_event` has no effect while `bus_master` is 0.
- R10: While `bus_master` is 1, a pending interrupt does not drive `irq_pull`. It appears on `irq_pull` in the first cycle with `bus_master` = 0.
- R11: Synchronous active-low reset clears the pending request, under-service, the sequence detector, the vector drive and the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_n | input | 1 | Opcode-fetch strobe, active low |
| ioreq_n | input | 1 | I/O request strobe, active low |
| data_in | input | 8 | Data bus as seen by the unit |
| bus_master | input | 1 | Unit currently owns the bus |
| irq_event | input | 1 | One-cycle internal interrupt-request event |
| pulse_event | input | 1 | One-cycle request for an output pulse |
| chain_en_in | input | 1 | Priority chain enable from the higher-priority neighbour |
| chain_en_out | output | 1 | Priority chain enable to the lower-priority neighbour |
| irq_pull | output | 1 | 1 = drive the open-drain request line low, 0 = release it |
| vec_out | output | 8 | Interrupt vector during a granted acknowledge |
| vec_oe | output | 1 | Vector output enable |

## Verification
The assertions assume that the strobes and the data bus are synchronous to `clk`. They assume the opcode byte is valid in the first cycle that `fetch_n` is low, and that during an acknowledge both strobes fall in the same cycle, so an acknowledge never looks like an opcode fetch. They also assume `chain_en_in` only changes between strobe cycles. The bench drives every input on the falling edge. Each fetch and each acknowledge is followed by a cycle with the strobes high, and acknowledges are always applied by lowering both strobes together. This keeps every stimulus inside those assumptions.

// File: rtl/irq_chain_pkg.sv
// Shared constants and types for the daisy-chain interrupt unit.
// Assumes: 8-bit opcode bytes; the return sequence is a fixed prefix/suffix pair.
package irq_chain_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam logic [BYTE_W-1:0] RET_PREFIX = 8'hED;
    localparam logic [BYTE_W-1:0] RET_SUFFIX = 8'h4D;

    typedef enum logic {
        SNOOP_IDLE  = 1'b0,
        SNOOP_ARMED = 1'b1
    } snoop_state_e;
endpackage

// File: rtl/strobe_decode.sv
// Turns the raw active-low bus strobes into one-cycle events.
// fetch_evt: first low cycle of the fetch strobe with the I/O strobe high.
// ack_evt:   first cycle in which both strobes are low together.
// ack_active: both strobes currently low.
// Assumes: strobes are synchronous to clk; during an acknowledge both fall together.
module strobe_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic fetch_n,
    input  logic ioreq_n,
    output logic fetch_evt,
    output logic ack_evt,
    output logic ack_active
);
    logic fetch_prev_n;
    logic ack_prev;

    // Remember last cycle's strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_prev_n <= 1'b1;
            ack_prev     <= 1'b0;
        end else begin
            fetch_prev_n <= fetch_n;
            ack_prev     <= ack_active;
        end
    end

    // Decode the events from current and previous levels.
    always_comb begin
        ack_active = !fetch_n && !ioreq_n;
        ack_evt    = ack_active && !ack_prev;
        fetch_evt  = !fetch_n && fetch_prev_n && ioreq_n;
    end
endmodule

// File: rtl/reti_snoop.sv
// Watches fetched opcode bytes for the two-byte return-from-interrupt sequence.
// reti_hit is high in the cycle the suffix byte is fetched right after the prefix.
// Assumes: fetch_evt marks a cycle in which data_in holds a valid opcode byte.
module reti_snoop
    import irq_chain_pkg::*;
#(
    parameter int unsigned          W      = BYTE_W,
    parameter logic [W-1:0]         PREFIX = RET_PREFIX,
    parameter logic [W-1:0]         SUFFIX = RET_SUFFIX
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fetch_evt,
    input  logic [W-1:0] data_in,
    output logic         reti_hit,
    output logic         armed
);
    snoop_state_e state_q;
    snoop_state_e state_d;

    // Next-state logic: a prefix (re)arms, anything else returns to idle.
    always_comb begin
        state_d  = state_q;
        reti_hit = 1'b0;
        if (fetch_evt) begin
            if (data_in == PREFIX) begin
                state_d = SNOOP_ARMED;
            end else begin
                state_d  = SNOOP_IDLE;
                reti_hit = (state_q == SNOOP_ARMED) && (data_in == SUFFIX);
            end
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SNOOP_IDLE;
        else        state_q <= state_d;
    end

    assign armed = (state_q == SNOOP_ARMED);

    // A completed sequence always leaves the detector idle.
    p_disarm_after_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reti_hit |=> !armed);

    // A fetch of a non-prefix byte never leaves the detector armed.
    p_abort_on_other_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_evt && data_in != PREFIX) |=> !armed);
endmodule

// File: rtl/chain_ctrl.sv
// Holds the pending and under-service state of the unit in the priority chain.
// Grants an acknowledge only with chain enable high and a request pending, and
// releases service on a return sequence only with chain enable high.
// Assumes: chain_en_in is stable across each strobe cycle.
module chain_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_event,
    input  logic ack_evt,
    input  logic ack_active,
    input  logic chain_en_in,
    input  logic reti_hit,
    output logic pending,
    output logic in_service,
    output logic vec_oe
);
    logic grant;

    // Acknowledge is ours only if no higher device blocks and we asked.
    assign grant = ack_evt && chain_en_in && pending;

    // Pending request: set by an event, cleared when the acknowledge is granted.
    always_ff @(posedge clk) begin
        if (!rst_n)         pending <= 1'b0;
        else if (irq_event) pending <= 1'b1;
        else if (grant)     pending <= 1'b0;
    end

    // Under-service flag: set on grant, cleared by a return seen while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                          in_service <= 1'b0;
        else if (grant)                      in_service <= 1'b1;
        else if (reti_hit && chain_en_in)    in_service <= 1'b0;
    end

    // Vector drive: on from grant for as long as the acknowledge lasts.
    always_ff @(posedge clk) begin
        if (!rst_n) vec_oe <= 1'b0;
        else        vec_oe <= grant || (vec_oe && ack_active);
    end

    // A granted acknowledge moves the request into service.
    p_grant_to_service_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_evt && chain_en_in && pending && !irq_event) |=> (in_service && !pending));

    // Blocked from above, the service state cannot be released.
    p_service_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_service && !chain_en_in) |=> in_service);

    // The vector is only ever driven inside or just after an acknowledge.
    p_vec_in_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |-> $past(ack_active));

    // An acknowledge without enable or request leaves the vector off.
    p_ignored_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_evt && (!chain_en_in || !pending)) |=> !vec_oe);
endmodule

// File: rtl/req_pin_mux.sv
// Chooses what drives the open-drain request line: the interrupt request while
// the unit is not bus master, a one-cycle pulse while it is.
// Assumes: pulse_event is a single-cycle strobe.
module req_pin_mux (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_master,
    input  logic pulse_event,
    input  logic pending,
    output logic irq_pull
);
    logic pulse_q;

    // Register a pulse request only while the bus is held.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= bus_master && pulse_event;
    end

    // Select the source of the line.
    always_comb begin
        if (bus_master) irq_pull = pulse_q;
        else            irq_pull = pending;
    end

    // Without a pulse request last cycle, mastership keeps the line released.
    p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_master && $past(bus_master) && !$past(pulse_event)) |-> !irq_pull);

    // Taking the bus never inherits a stale pulse or a request.
    p_master_masks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_master) |-> !irq_pull);
endmodule

// File: rtl/irq_chain_unit.sv
// Top of the daisy-chain interrupt unit. Connects strobe decoding, return
// snooping, chain state and the request-line mux, and drives the chain output
// and the vector bus.
// Assumes: all inputs synchronous to clk; irq_pull=1 means pull the shared line low.
module irq_chain_unit
    import irq_chain_pkg::*;
#(
    parameter int unsigned         W      = BYTE_W,
    parameter logic [W-1:0]        VEC_ID = 8'hA4,
    parameter logic [W-1:0]        PREFIX = RET_PREFIX,
    parameter logic [W-1:0]        SUFFIX = RET_SUFFIX
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fetch_n,
    input  logic         ioreq_n,
    input  logic [W-1:0] data_in,
    input  logic         bus_master,
    input  logic         irq_event,
    input  logic         pulse_event,
    input  logic         chain_en_in,
    output logic         chain_en_out,
    output logic         irq_pull,
    output logic [W-1:0] vec_out,
    output logic         vec_oe
);
    logic fetch_evt;
    logic ack_evt;
    logic ack_active;
    logic reti_hit;
    logic armed;
    logic pending;
    logic in_service;

    strobe_decode u_strobe (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_n    (fetch_n),
        .ioreq_n    (ioreq_n),
        .fetch_evt  (fetch_evt),
        .ack_evt    (ack_evt),
        .ack_active (ack_active)
    );

    reti_snoop #(
        .W      (W),
        .PREFIX (PREFIX),
        .SUFFIX (SUFFIX)
    ) u_snoop (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_evt (fetch_evt),
        .data_in   (data_in),
        .reti_hit  (reti_hit),
        .armed     (armed)
    );

    chain_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_event   (irq_event),
        .ack_evt     (ack_evt),
        .ack_active  (ack_active),
        .chain_en_in (chain_en_in),
        .reti_hit    (reti_hit),
        .pending     (pending),
        .in_service  (in_service),
        .vec_oe      (vec_oe)
    );

    req_pin_mux u_pin (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_master  (bus_master),
        .pulse_event (pulse_event),
        .pending     (pending),
        .irq_pull    (irq_pull)
    );

    // Chain output: pass a block from above, add our own while active.
    assign chain_en_out = chain_en_in && !pending && !in_service;

    // Vector bus: our identifier only while the vector is enabled.
    assign vec_out = vec_oe ? VEC_ID : '0;

    // A block from above always reaches the lower neighbours.
    p_block_passes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_en_in |-> !chain_en_out);

    // The vector is only driven while this unit holds service.
    p_vec_needs_service_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |-> in_service);
endmodule

// File: tb/irq_chain_unit_bench.sv
// Self-checking bench: a vector table walked by one loop, then directed tests.
module irq_chain_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_ROWS = 31;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fetch_n = 1'b1;
    logic       ioreq_n = 1'b1;
    logic [7:0] data_in = 8'h00;
    logic       bus_master = 1'b0;
    logic       irq_event = 1'b0;
    logic       pulse_event = 1'b0;
    logic       chain_en_in = 1'b1;
    logic       chain_en_out;
    logic       irq_pull;
    logic [7:0] vec_out;
    logic       vec_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_chain_unit u_irq_chain_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_n      (fetch_n),
        .ioreq_n      (ioreq_n),
        .data_in      (data_in),
        .bus_master   (bus_master),
        .irq_event    (irq_event),
        .pulse_event  (pulse_event),
        .chain_en_in  (chain_en_in),
        .chain_en_out (chain_en_out),
        .irq_pull     (irq_pull),
        .vec_out      (vec_out),
        .vec_oe       (vec_oe)
    );

    // Row: req tag, fetch_n, ioreq_n, data, master, irq_ev, pulse_ev, en_in | exp pull, en_out, vec_oe
    function automatic logic [20:0] row(input logic [3:0] rq, input logic f, input logic i,
                                        input logic [7:0] d, input logic m, input logic e,
                                        input logic p, input logic n, input logic xp,
                                        input logic xe, input logic xv);
        return {rq, f, i, d, m, e, p, n, xp, xe, xv};
    endfunction

    localparam logic [20:0] TBL [N_ROWS] = '{
        row(4'd5,  1,1,8'h00, 0,0,0,1, 0,1,0), // R5 idle passes chain
        row(4'd1,  1,1,8'h00, 0,1,0,1, 1,0,0), // R1 event -> request
        row(4'd1,  1,1,8'h00, 0,0,0,1, 1,0,0), // R1 request held
        row(4'd4,  0,0,8'h00, 0,0,0,0, 1,0,0), // R4 ack blocked from above
        row(4'd4,  1,1,8'h00, 0,0,0,1, 1,0,0), // R4 request still pending
        row(4'd3,  0,0,8'h00, 0,0,0,1, 0,0,1), // R3 granted ack
        row(4'd3,  0,0,8'h00, 0,0,0,1, 0,0,1), // R3 vector held while strobes low
        row(4'd5,  1,1,8'h00, 0,0,0,1, 0,0,0), // R5 service blocks chain
        row(4'd8,  0,1,8'hED, 0,0,0,1, 0,0,0), // R8 prefix
        row(4'd8,  1,1,8'h00, 0,0,0,1, 0,0,0),
        row(4'd8,  0,1,8'h00, 0,0,0,1, 0,0,0), // R8 other byte aborts
        row(4'd8,  1,1,8'h00, 0,0,0,1, 0,0,0),
        row(4'd8,  0,1,8'h4D, 0,0,0,1, 0,0,0), // R8 lone suffix ignored
        row(4'd8,  1,1,8'h00, 0,0,0,1, 0,0,0),
        row(4'd8,  0,1,8'hED, 0,0,0,1, 0,0,0), // R8 prefix
        row(4'd8,  1,1,8'h00, 0,0,0,1, 0,0,0),
        row(4'd8,  0,1,8'hED, 0,0,0,1, 0,0,0), // R8 second prefix re-arms
        row(4'd8,  1,1,8'h00, 0,0,0,1, 0,0,0),
        row(4'd7,  0,1,8'h4D, 0,0,0,0, 0,0,0), // R7 suffix while blocked
        row(4'd7,  1,1,8'h00, 0,0,0,1, 0,0,0), // R7 service kept
        row(4'd6,  0,1,8'hED, 0,0,0,1, 0,0,0), // R6 prefix
        row(4'd6,  1,1,8'h00, 0,0,0,1, 0,0,0),
        row(4'd6,  0,1,8'h4D, 0,0,0,1, 0,1,0), // R6 return releases service
        row(4'd6,  1,1,8'h00, 0,0,0,1, 0,1,0),
        row(4'd9,  1,1,8'h00, 1,0,1,1, 1,1,0), // R9 pulse while master
        row(4'd9,  1,1,8'h00, 1,0,0,1, 0,1,0), // R9 pulse lasts one cycle
        row(4'd10, 1,1,8'h00, 1,1,0,1, 0,0,0), // R10 request masked
        row(4'd10, 1,1,8'h00, 1,0,0,1, 0,0,0), // R10 still masked
        row(4'd10, 1,1,8'h00, 0,0,0,1, 1,0,0), // R10 presented after release
        row(4'd3,  0,0,8'h00, 0,0,0,1, 0,0,1), // R3 second grant
        row(4'd3,  1,1,8'h00, 0,0,0,1, 0,0,0)  // R3 vector off after strobes rise
    };

    task automatic chk(input int rq, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // Drive at the falling edge, let one rising edge pass, sample at the next falling edge.
    task automatic step(input logic f, input logic i, input logic [7:0] d, input logic m,
                        input logic e, input logic p, input logic n);
        fetch_n = f; ioreq_n = i; data_in = d; bus_master = m;
        irq_event = e; pulse_event = p; chain_en_in = n;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 5000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        @(negedge clk);
        rst_n = 1'b0;
        step(1,1,8'h00,0,0,0,1);
        step(1,1,8'h00,0,0,0,1);
        rst_n = 1'b1;
        // R11 reset state
        chk(11, "reset irq_pull", {7'd0, irq_pull}, 8'd0);
        chk(11, "reset chain_en_out", {7'd0, chain_en_out}, 8'd1);
        chk(11, "reset vec_oe", {7'd0, vec_oe}, 8'd0);
        chk(11, "reset vec_out", vec_out, 8'h00);

        for (int k = 0; k < N_ROWS; k++) begin
            logic [20:0] r;
            r = TBL[k];
            step(r[16], r[15], r[14:7], r[6], r[5], r[4], r[3]);
            chk(int'(r[20:17]), $sformatf("row %0d irq_pull", k), {7'd0, irq_pull}, {7'd0, r[2]});
            chk(int'(r[20:17]), $sformatf("row %0d chain_en_out", k), {7'd0, chain_en_out}, {7'd0, r[1]});
            chk(int'(r[20:17]), $sformatf("row %0d vec_oe", k), {7'd0, vec_oe}, {7'd0, r[0]});
        end

        // R3 vector value during a grant (unit is in service with nothing pending here)
        step(1,1,8'h00,0,1,0,1);
        step(0,0,8'h00,0,0,0,1);
        chk(3, "vec_out during grant", vec_out, 8'hA4);
        step(1,1,8'h00,0,0,0,1);
        chk(3, "vec_out after ack", vec_out, 8'h00);

        // R11 reset while under service clears it
        rst_n = 1'b0;
        step(1,1,8'h00,0,0,0,1);
        rst_n = 1'b1;
        chk(11, "reset in service chain_en_out", {7'd0, chain_en_out}, 8'd1);

        // R9 pulse ignored while not master
        step(1,1,8'h00,0,0,1,1);
        chk(9, "pulse without mastership", {7'd0, irq_pull}, 8'd0);

        // R2 I/O strobe alone, then fetch strobe alone, are not acknowledges
        step(1,1,8'h00,0,1,0,1);
        step(1,0,8'h00,0,0,0,1);
        chk(2, "ioreq alone vec_oe", {7'd0, vec_oe}, 8'd0);
        step(1,1,8'h00,0,0,0,1);
        step(0,1,8'h11,0,0,0,1);
        chk(2, "fetch alone vec_oe", {7'd0, vec_oe}, 8'd0);
        chk(2, "request still pending", {7'd0, irq_pull}, 8'd1);
        step(1,1,8'h00,0,0,0,1);

        // R4 acknowledge with nothing pending does nothing
        step(0,0,8'h00,0,0,0,1);
        step(1,1,8'h00,0,0,0,1);
        step(0,0,8'h00,0,0,0,1);
        chk(4, "ack with no request vec_oe", {7'd0, vec_oe}, 8'd0);
        step(1,1,8'h00,0,0,0,1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule